// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the control strobes of an asynchronous DRAM bus: one row strobe, several independent column strobe lanes, a write strobe and an output enable. It samples all of them on a fast system clock. From the order in which the strobe edges arrive, it works out what kind of memory cycle the controller ran. One report is produced each time the row strobe is released. The report carries the cycle kind, the row address captured at the row strobe fall, the column address of the last column strobe, and the set of lanes that were active during the cycle.

The block also measures every strobe pulse in clock samples. It flags any low pulse or precharge gap that is shorter than a configured minimum. Each such event raises a one-clock violation pulse with a code and, for column strobes, the offending lanes. The block is a passive monitor for testbenches or for on-chip debug of a memory controller, and it never drives the bus.

All strobes are active low. A column strobe (a "strobe" below) starts when at least one lane goes low after a sample in which every lane was high.

Top module: `dram_cycle_mon`

## Requirements
- R1: After reset, with all strobes held high, `rpt_valid` and `viol_valid` stay low.
- R2: A cycle with one strobe, write strobe high at the strobe start and never falling, is reported as kind 0 (read). The row is the address sampled when the row strobe falls. The column is the address sampled at the strobe start.
- R3: If the write strobe is low when the strobe starts, a single-strobe cycle is reported as kind 1 (early write).
- R4: If the write strobe falls while a lane is still low and output enable was never seen low in that strobe, the cycle is reported as kind 2 (late write).
- R5: If output enable was seen low during the strobe before the write strobe falls, the cycle is reported as kind 3 (read-modify-write).
- R6: A row strobe low period with every lane high throughout is reported as kind 4 (row-only refresh), with lanes 0 and column 0.
- R7: If any lane is low when the row strobe falls and the write strobe is high, the cycle is reported as kind 5 (column-before-row refresh). Row and column are 0, and the lanes are those low during the cycle.
- R8: If any lane is low and the write strobe is also low when the row strobe falls, the cycle is reported as kind 8 (test-mode entry).
- R9: If a lane stays low continuously from the end of an access cycle until the next row strobe fall, the new cycle is reported as kind 6 (hidden refresh).
- R10: Two or more strobes within one row strobe low period are reported as kind 7 (page mode). The column comes from the last strobe and the lanes are the OR of all lanes strobed.
- R11: The column is captured only by the first lane to fall in a strobe. Lanes that fall later in the same strobe add to the lane mask but do not recapture the column.
- R12: `rpt_valid` is high for exactly one clock, registered at the first clock edge that samples the row strobe high after a low period.
- R13: A low pulse shorter than its minimum number of samples raises `viol_valid` for one clock, registered at the rising-edge sample. The code is 0 for the row strobe and 2 for a lane. A high gap shorter than its minimum raises the pulse at the falling-edge sample, with code 1 for the row strobe and 3 for a lane. For lane codes, `viol_lanes` marks the lanes that failed.
- R14: When several violations occur in the same clock, only the lowest code is reported. `viol_lanes` is 0 when the reported code is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobe lanes, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address bus |
| rpt_valid | output | 1 | One-clock cycle report pulse |
| rpt_kind | output | 4 | Decoded cycle kind (codes in R2 to R10) |
| rpt_row | output | ADDR_W | Captured row address |
| rpt_col | output | ADDR_W | Captured column address |
| rpt_lanes | output | LANES | Lanes active during the cycle |
| viol_valid | output | 1 | One-clock pulse-width violation |
| viol_code | output | 2 | Violation code (R13) |
| viol_lanes | output | LANES | Lanes that broke a lane minimum |

## Verification
Every cycle kind is driven once with distinct row, column and lane values. The read, early write, late write and read-modify-write cases differ only in the timing of the write strobe and output enable relative to the strobe start, so the bench shows whether the classifier separates them by edge order. The refresh cases hold a lane low across the row strobe fall, with and without the write strobe and with and without a preceding access. Staggered lanes and a two-strobe page check which address capture and lane merging occur. Each minimum is broken in its own run, and one run breaks two minimums together to test the violation priority.

// File: rtl/dram_mon_pkg.sv
package dram_mon_pkg;

    typedef enum logic [3:0] {
        CYC_READ     = 4'd0,
        CYC_EARLY_WR = 4'd1,
        CYC_LATE_WR  = 4'd2,
        CYC_RMW      = 4'd3,
        CYC_ROW_ONLY = 4'd4,
        CYC_CBR      = 4'd5,
        CYC_HIDDEN   = 4'd6,
        CYC_PAGE     = 4'd7,
        CYC_TEST_IN  = 4'd8
    } cyc_kind_e;

    typedef enum logic [1:0] {
        VIO_RAS_LOW = 2'd0,
        VIO_RAS_PRE = 2'd1,
        VIO_CAS_LOW = 2'd2,
        VIO_CAS_PRE = 2'd3
    } vio_code_e;

    typedef enum logic [1:0] {
        MD_ACCESS,
        MD_CBR,
        MD_TEST,
        MD_HIDDEN
    } ras_mode_e;

    typedef struct packed {
        logic ras_fell;
        logic ras_rose;
        logic col_start;
        logic we_fell;
    } strobe_ev_t;

    function automatic logic is_access_kind(input logic [3:0] k);
        return (k <= 4'd3) || (k == 4'd7);
    endfunction

    function automatic logic is_refresh_kind(input logic [3:0] k);
        return (k == 4'd5) || (k == 4'd6) || (k == 4'd8);
    endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import dram_mon_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    output strobe_ev_t       ev,
    output logic [LANES-1:0] cas_fell,
    output logic [LANES-1:0] cas_rose
);
    logic             ras_q;
    logic [LANES-1:0] cas_q;
    logic             we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= '1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        ev.ras_fell  = ras_q & ~ras_n;
        ev.ras_rose  = ~ras_q & ras_n;
        ev.col_start = (&cas_q) & ~(&cas_n);
        ev.we_fell   = we_q & ~we_n;
        cas_fell     = cas_q & ~cas_n;
        cas_rose     = ~cas_q & cas_n;
    end

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int unsigned LOW_MIN  = 4,
    parameter int unsigned HIGH_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic fell,
    input  logic rose,
    output logic short_low,
    output logic short_high
);
    localparam int unsigned TOP = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
    localparam int unsigned CW  = $clog2(TOP + 1);
    localparam logic [CW-1:0] LMAX = CW'(LOW_MIN);
    localparam logic [CW-1:0] HMAX = CW'(HIGH_MIN);

    logic [CW-1:0] cnt_low;
    logic [CW-1:0] cnt_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_low  <= '0;
            cnt_high <= HMAX;
        end else if (fell) begin
            cnt_low <= CW'(1);
        end else if (rose) begin
            cnt_high <= CW'(1);
        end else if (!lvl) begin
            if (cnt_low < LMAX) cnt_low <= cnt_low + CW'(1);
        end else begin
            if (cnt_high < HMAX) cnt_high <= cnt_high + CW'(1);
        end
    end

    assign short_low  = rose && (cnt_low < LMAX);
    assign short_high = fell && (cnt_high < HMAX);

    assert_low_only_at_rise_R13: assert property (@(posedge clk) disable iff (rst)
        short_low |-> (lvl && $past(!lvl)));

endmodule

// File: rtl/cycle_decoder.sv
module cycle_decoder
    import dram_mon_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_ev_t        ev,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rpt_valid,
    output logic [3:0]        rpt_kind,
    output logic [ADDR_W-1:0] rpt_row,
    output logic [ADDR_W-1:0] rpt_col,
    output logic [LANES-1:0]  rpt_lanes
);
    logic              active;
    ras_mode_e         mode;
    logic [ADDR_W-1:0] row_r;
    logic [ADDR_W-1:0] col_r;
    logic [LANES-1:0]  lanes_r;
    logic [1:0]        strobes;
    cyc_kind_e         acc_kind;
    logic              oe_seen;
    logic              w_open;
    logic              hidden_arm;
    cyc_kind_e         final_kind;
    logic              cas_low_any;

    assign cas_low_any = ~(&cas_n);

    always_comb begin
        unique case (mode)
            MD_CBR:    final_kind = CYC_CBR;
            MD_TEST:   final_kind = CYC_TEST_IN;
            MD_HIDDEN: final_kind = CYC_HIDDEN;
            default: begin
                if (strobes == 2'd0)      final_kind = CYC_ROW_ONLY;
                else if (strobes >= 2'd2) final_kind = CYC_PAGE;
                else                      final_kind = acc_kind;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            mode       <= MD_ACCESS;
            row_r      <= '0;
            col_r      <= '0;
            lanes_r    <= '0;
            strobes    <= 2'd0;
            acc_kind   <= CYC_READ;
            oe_seen    <= 1'b0;
            w_open     <= 1'b0;
            hidden_arm <= 1'b0;
            rpt_valid  <= 1'b0;
            rpt_kind   <= 4'd0;
            rpt_row    <= '0;
            rpt_col    <= '0;
            rpt_lanes  <= '0;
        end else begin
            rpt_valid <= 1'b0;
            if (ev.ras_fell) begin
                active     <= 1'b1;
                strobes    <= 2'd0;
                col_r      <= '0;
                acc_kind   <= CYC_READ;
                oe_seen    <= 1'b0;
                w_open     <= 1'b0;
                lanes_r    <= ~cas_n;
                hidden_arm <= 1'b0;
                if (cas_low_any) begin
                    row_r <= '0;
                    if (hidden_arm)  mode <= MD_HIDDEN;
                    else if (!we_n)  mode <= MD_TEST;
                    else             mode <= MD_CBR;
                end else begin
                    row_r <= addr;
                    mode  <= MD_ACCESS;
                end
            end else if (ev.ras_rose && active) begin
                active     <= 1'b0;
                rpt_valid  <= 1'b1;
                rpt_kind   <= final_kind;
                rpt_row    <= row_r;
                rpt_col    <= col_r;
                rpt_lanes  <= lanes_r;
                hidden_arm <= cas_low_any &&
                              ((mode == MD_ACCESS && strobes != 2'd0) || mode == MD_HIDDEN);
            end else if (active) begin
                lanes_r <= lanes_r | ~cas_n;
                if (mode == MD_ACCESS) begin
                    if (ev.col_start) begin
                        col_r <= addr;
                        if (strobes != 2'd2) strobes <= strobes + 2'd1;
                        if (strobes == 2'd0) begin
                            acc_kind <= we_n ? CYC_READ : CYC_EARLY_WR;
                            oe_seen  <= ~oe_n;
                            w_open   <= we_n;
                        end else begin
                            w_open <= 1'b0;
                        end
                    end else if (cas_low_any) begin
                        if (!oe_n) oe_seen <= 1'b1;
                        if (ev.we_fell && w_open) begin
                            acc_kind <= oe_seen ? CYC_RMW : CYC_LATE_WR;
                            w_open   <= 1'b0;
                        end
                    end
                end
            end else if (!cas_low_any) begin
                hidden_arm <= 1'b0;
            end
        end
    end

    assert_refresh_no_col_R7: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && is_refresh_kind(rpt_kind)) |-> (rpt_col == '0 && rpt_row == '0));

    assert_row_only_no_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_kind == 4'd4) |-> (rpt_lanes == '0));

    assert_access_has_lane_R2: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && is_access_kind(rpt_kind)) |-> (rpt_lanes != '0));

endmodule

// File: rtl/dram_cycle_mon.sv
module dram_cycle_mon
    import dram_mon_pkg::*;
#(
    parameter int unsigned LANES       = 4,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned RAS_LOW_MIN = 4,
    parameter int unsigned RAS_PRE_MIN = 3,
    parameter int unsigned CAS_LOW_MIN = 2,
    parameter int unsigned CAS_PRE_MIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rpt_valid,
    output logic [3:0]        rpt_kind,
    output logic [ADDR_W-1:0] rpt_row,
    output logic [ADDR_W-1:0] rpt_col,
    output logic [LANES-1:0]  rpt_lanes,
    output logic              viol_valid,
    output logic [1:0]        viol_code,
    output logic [LANES-1:0]  viol_lanes
);
    strobe_ev_t       ev;
    logic [LANES-1:0] cas_fell;
    logic [LANES-1:0] cas_rose;
    logic             ras_short_low;
    logic             ras_short_high;
    logic [LANES-1:0] cas_short_low;
    logic [LANES-1:0] cas_short_high;

    strobe_sampler #(.LANES(LANES)) sampler_i (
        .clk      (clk),
        .rst      (rst),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ev       (ev),
        .cas_fell (cas_fell),
        .cas_rose (cas_rose)
    );

    pulse_timer #(.LOW_MIN(RAS_LOW_MIN), .HIGH_MIN(RAS_PRE_MIN)) ras_timer_i (
        .clk        (clk),
        .rst        (rst),
        .lvl        (ras_n),
        .fell       (ev.ras_fell),
        .rose       (ev.ras_rose),
        .short_low  (ras_short_low),
        .short_high (ras_short_high)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pulse_timer #(.LOW_MIN(CAS_LOW_MIN), .HIGH_MIN(CAS_PRE_MIN)) cas_timer_i (
            .clk        (clk),
            .rst        (rst),
            .lvl        (cas_n[g]),
            .fell       (cas_fell[g]),
            .rose       (cas_rose[g]),
            .short_low  (cas_short_low[g]),
            .short_high (cas_short_high[g])
        );
    end

    cycle_decoder #(.LANES(LANES), .ADDR_W(ADDR_W)) decoder_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .rpt_valid (rpt_valid),
        .rpt_kind  (rpt_kind),
        .rpt_row   (rpt_row),
        .rpt_col   (rpt_col),
        .rpt_lanes (rpt_lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_valid <= 1'b0;
            viol_code  <= 2'd0;
            viol_lanes <= '0;
        end else begin
            viol_valid <= ras_short_low | ras_short_high |
                          (|cas_short_low) | (|cas_short_high);
            viol_lanes <= '0;
            if (ras_short_low) begin
                viol_code <= VIO_RAS_LOW;
            end else if (ras_short_high) begin
                viol_code <= VIO_RAS_PRE;
            end else if (|cas_short_low) begin
                viol_code  <= VIO_CAS_LOW;
                viol_lanes <= cas_short_low;
            end else begin
                viol_code  <= VIO_CAS_PRE;
                viol_lanes <= cas_short_high;
            end
        end
    end

    assert_rpt_after_rise_R12: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> ($past(ras_n) && !$past(ras_n, 2)));

    assert_rpt_single_R12: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |=> !rpt_valid);

    assert_ras_low_at_rise_R13: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && viol_code == 2'd0) |-> ($past(ras_n) && !$past(ras_n, 2)));

    assert_ras_code_no_lanes_R14: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && viol_code <= 2'd1) |-> (viol_lanes == '0));

    assert_cas_code_has_lanes_R13: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && viol_code >= 2'd2) |-> (viol_lanes != '0));

endmodule

// File: tb/dram_cycle_mon_tb_top.sv
`timescale 1ns/1ps
module dram_cycle_mon_tb_top;

    localparam int LANES  = 4;
    localparam int ADDR_W = 12;

    typedef struct {
        logic [3:0]        kind;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [LANES-1:0]  lanes;
        string             req;
    } exp_rpt_t;

    typedef struct {
        logic [1:0]       code;
        logic [LANES-1:0] lanes;
        string            req;
    } exp_vio_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ras_n = 1'b1;
    logic [LANES-1:0]  cas_n = '1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              rpt_valid;
    logic [3:0]        rpt_kind;
    logic [ADDR_W-1:0] rpt_row;
    logic [ADDR_W-1:0] rpt_col;
    logic [LANES-1:0]  rpt_lanes;
    logic              viol_valid;
    logic [1:0]        viol_code;
    logic [LANES-1:0]  viol_lanes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_rpt_t rq[$];
    exp_vio_t vq[$];

    always #2 clk = ~clk;

    dram_cycle_mon dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .rpt_valid(rpt_valid), .rpt_kind(rpt_kind),
        .rpt_row(rpt_row), .rpt_col(rpt_col), .rpt_lanes(rpt_lanes),
        .viol_valid(viol_valid), .viol_code(viol_code), .viol_lanes(viol_lanes)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic want_rpt(input logic [3:0] k, input logic [ADDR_W-1:0] r,
                            input logic [ADDR_W-1:0] c, input logic [LANES-1:0] l,
                            input string req);
        exp_rpt_t e;
        e.kind = k; e.row = r; e.col = c; e.lanes = l; e.req = req;
        rq.push_back(e);
    endtask

    task automatic want_vio(input logic [1:0] code, input logic [LANES-1:0] l,
                            input string req);
        exp_vio_t e;
        e.code = code; e.lanes = l; e.req = req;
        vq.push_back(e);
    endtask

    // Monitor: pops expectations as the design reports
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rpt_valid) begin
                checks++;
                if (rq.size() == 0) begin
                    errors++;
                    $display("FAIL R12: unexpected report kind=%0d row=%h col=%h lanes=%b, expected none",
                             rpt_kind, rpt_row, rpt_col, rpt_lanes);
                end else begin
                    exp_rpt_t e;
                    e = rq.pop_front();
                    if (rpt_kind !== e.kind || rpt_row !== e.row ||
                        rpt_col !== e.col || rpt_lanes !== e.lanes) begin
                        errors++;
                        $display("FAIL %s: report kind=%0d row=%h col=%h lanes=%b, expected kind=%0d row=%h col=%h lanes=%b",
                                 e.req, rpt_kind, rpt_row, rpt_col, rpt_lanes,
                                 e.kind, e.row, e.col, e.lanes);
                    end
                end
            end
            if (viol_valid) begin
                checks++;
                if (vq.size() == 0) begin
                    errors++;
                    $display("FAIL R13: unexpected violation code=%0d lanes=%b, expected none",
                             viol_code, viol_lanes);
                end else begin
                    exp_vio_t v;
                    v = vq.pop_front();
                    if (viol_code !== v.code || viol_lanes !== v.lanes) begin
                        errors++;
                        $display("FAIL %s: violation code=%0d lanes=%b, expected code=%0d lanes=%b",
                                 v.req, viol_code, viol_lanes, v.code, v.lanes);
                    end
                end
            end
        end
    end

    // wmode: 0 read, 1 early write, 2 late write, 3 read-modify-write
    task automatic access(input logic [ADDR_W-1:0] row, input logic [ADDR_W-1:0] col,
                          input logic [LANES-1:0] lanes, input int wmode, input string req);
        addr = row; ras_n = 1'b0;
        step(1);
        addr = col; cas_n = ~lanes;
        we_n = (wmode == 1) ? 1'b0 : 1'b1;
        oe_n = (wmode == 3) ? 1'b0 : 1'b1;
        step(1);
        if (wmode >= 2) begin we_n = 1'b0; oe_n = 1'b1; end
        step(1);
        cas_n = '1; we_n = 1'b1; oe_n = 1'b1;
        step(1);
        ras_n = 1'b1;
        want_rpt(4'(wmode), row, col, lanes, req);
        step(4);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(3);
        // R1: reset state
        checks++;
        if (rpt_valid !== 1'b0 || viol_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rpt_valid=%b viol_valid=%b, expected 0 0", rpt_valid, viol_valid);
        end

        access(12'h1A3, 12'h045, 4'b0001, 0, "R2");
        access(12'h2B4, 12'h156, 4'b0011, 1, "R3");
        access(12'h3C5, 12'h267, 4'b0100, 2, "R4");
        access(12'h4D6, 12'h378, 4'b1111, 3, "R5");

        // R6: row-only refresh
        addr = 12'h5E7; ras_n = 1'b0;
        step(4);
        ras_n = 1'b1; want_rpt(4'd4, 12'h5E7, 12'h000, 4'b0000, "R6");
        step(4);

        // R7: column-before-row refresh
        cas_n = 4'b1110; addr = 12'h777;
        step(1);
        ras_n = 1'b0;
        step(4);
        ras_n = 1'b1; want_rpt(4'd5, 12'h000, 12'h000, 4'b0001, "R7");
        step(1);
        cas_n = '1;
        step(4);

        // R8: test-mode entry
        cas_n = 4'b1011; we_n = 1'b0;
        step(1);
        ras_n = 1'b0;
        step(4);
        ras_n = 1'b1; want_rpt(4'd8, 12'h000, 12'h000, 4'b0100, "R8");
        step(1);
        cas_n = '1; we_n = 1'b1;
        step(4);

        // R9: read with lane held low, then hidden refresh
        addr = 12'h612; ras_n = 1'b0;
        step(1);
        addr = 12'h0AB; cas_n = 4'b1101; oe_n = 1'b0;
        step(3);
        ras_n = 1'b1; want_rpt(4'd0, 12'h612, 12'h0AB, 4'b0010, "R9");
        step(3);
        ras_n = 1'b0;
        step(4);
        ras_n = 1'b1; want_rpt(4'd6, 12'h000, 12'h000, 4'b0010, "R9");
        step(1);
        cas_n = '1; oe_n = 1'b1;
        step(4);

        // R10: page mode, two strobes
        addr = 12'h7F0; ras_n = 1'b0;
        step(1);
        addr = 12'h011; cas_n = 4'b1110;
        step(2);
        cas_n = '1;
        step(2);
        addr = 12'h022; cas_n = 4'b0111;
        step(2);
        cas_n = '1;
        step(1);
        ras_n = 1'b1; want_rpt(4'd7, 12'h7F0, 12'h022, 4'b1001, "R10");
        step(4);

        // R11: staggered lanes, column from first lane only
        addr = 12'h123; ras_n = 1'b0;
        step(1);
        addr = 12'h0C1; cas_n = 4'b1110;
        step(1);
        addr = 12'h0D2; cas_n = 4'b1100;
        step(2);
        cas_n = '1;
        step(1);
        ras_n = 1'b1; want_rpt(4'd0, 12'h123, 12'h0C1, 4'b0011, "R11");
        step(4);

        // R13: short row strobe low
        addr = 12'h321; ras_n = 1'b0;
        step(2);
        ras_n = 1'b1;
        want_rpt(4'd4, 12'h321, 12'h000, 4'b0000, "R13");
        want_vio(2'd0, 4'b0000, "R13");
        step(4);

        // R13: short row precharge
        addr = 12'h432; ras_n = 1'b0;
        step(4);
        ras_n = 1'b1; want_rpt(4'd4, 12'h432, 12'h000, 4'b0000, "R13");
        step(1);
        addr = 12'h543; ras_n = 1'b0; want_vio(2'd1, 4'b0000, "R13");
        step(4);
        ras_n = 1'b1; want_rpt(4'd4, 12'h543, 12'h000, 4'b0000, "R13");
        step(4);

        // R13: short lane low
        addr = 12'h654; ras_n = 1'b0;
        step(1);
        addr = 12'h0E3; cas_n = 4'b0111;
        step(1);
        cas_n = '1; want_vio(2'd2, 4'b1000, "R13");
        step(2);
        ras_n = 1'b1; want_rpt(4'd0, 12'h654, 12'h0E3, 4'b1000, "R13");
        step(4);

        // R13: short lane precharge
        addr = 12'h765; ras_n = 1'b0;
        step(1);
        addr = 12'h0F4; cas_n = 4'b1011;
        step(2);
        cas_n = '1;
        step(1);
        addr = 12'h0F5; cas_n = 4'b1011; want_vio(2'd3, 4'b0100, "R13");
        step(2);
        cas_n = '1;
        step(1);
        ras_n = 1'b1; want_rpt(4'd7, 12'h765, 12'h0F5, 4'b0100, "R13");
        step(4);

        // R14: short row low and short lane low together
        addr = 12'h876; ras_n = 1'b0;
        step(1);
        addr = 12'h0A0; cas_n = 4'b1110;
        step(1);
        ras_n = 1'b1; cas_n = '1;
        want_rpt(4'd0, 12'h876, 12'h0A0, 4'b0001, "R14");
        want_vio(2'd0, 4'b0000, "R14");
        step(6);

        done = 1'b1;
        while (rq.size() != 0) begin
            exp_rpt_t e;
            e = rq.pop_front();
            checks++; errors++;
            $display("FAIL %s: report missing, actual none, expected kind=%0d", e.req, e.kind);
        end
        while (vq.size() != 0) begin
            exp_vio_t v;
            v = vq.pop_front();
            checks++; errors++;
            $display("FAIL %s: violation missing, actual none, expected code=%0d", v.req, v.code);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R12: watchdog expired, actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule